// File: doc/BRIEF.md
# Rope Memory Emulator Address Responder

This block takes the place of a bank of woven read-only memory modules in a vintage computer. The host selects a word by raising one line in a module group and one line in a strand group, and it presents a 9-bit binary core position alongside them. A separate timing strobe from the host says when the word must be returned.

Every select input is synchronised and passed through a pulse-width filter. Spurious pulses caused by skew between host lines therefore never reach the address. Once the filtered selects settle, the block turns them into a linear word address. Each module holds 6144 words, which is not a power of two, so the address is computed arithmetically and not by concatenating fields. The block latches that address and waits for the timing strobe. It then reads a 16-bit word and its parity bit from a synchronous backing RAM and presents them to the host with a valid flag.

A select pattern that does not name exactly one module and exactly one strand is reported as a fault, and no word is returned for it.

Top module: `rope_addr_responder`

## Requirements
- R1: The linear address is module_index*6144 + strand_index*512 + core_position. The module index (0..5) is the bit position of the active `mod_sel_i` line, the strand index (0..11) is the bit position of the active `strand_sel_i` line, and `core_pos_i` is a 9-bit binary value.
- R2: A read is a single-cycle pulse on `ram_rd_o` with the address on `ram_addr_o`. The RAM returns its data one cycle later, and that data is captured. `ram_addr_o` does not change from the read until the response is finished.
- R3: The address is latched when the filtered selects are non-zero and unchanged for one cycle. Later changes on the select inputs do not alter the latched address.
- R4: No RAM read happens and `valid_o` stays low until the synchronised timing strobe is high.
- R5: During a response, `data_o` equals the RAM word, `par_o` equals the RAM parity bit, and `valid_o` is 1.
- R6: `data_o`, `par_o` and `valid_o` hold while the timing strobe stays high. After the strobe falls, all three return to 0. A new access starts only after every select line has been released.
- R7: A pulse shorter than MIN_PULSE clocks (default 3) on any select input has no effect. It is not latched, it causes no fault, and no read follows it.
- R8: If zero lines, or more than one line, are active in the module group or in the strand group when the address is latched, `err_o` rises and no read or valid follows. `err_o` falls once every select line is released.
- R9: A select pulse lasting exactly MIN_PULSE clocks is accepted as a real select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_sel_i | input | 6 | One-hot module select from host |
| strand_sel_i | input | 12 | One-hot strand select from host |
| core_pos_i | input | 9 | Binary core position within strand |
| timing_i | input | 1 | Host timing strobe |
| ram_rd_o | output | 1 | Backing RAM read pulse |
| ram_addr_o | output | 16 | Latched linear word address |
| ram_rdata_i | input | 16 | Backing RAM read word |
| ram_rpar_i | input | 1 | Backing RAM parity bit |
| data_o | output | 16 | Word returned to host |
| par_o | output | 1 | Parity returned to host |
| valid_o | output | 1 | Returned word is valid |
| err_o | output | 1 | Select pattern fault |

## Verification
Several accesses probe the address arithmetic, and each one separates a different wrong implementation:
- The zero corner and the top corner (module 5, strand 11, core 511) test the ends of the range.
- Module 1 at offset 0 must give 6144, which a field concatenation would turn into 8192.
- A mid-range access checks that the strand and core terms are added correctly.

Pulse tests tell a filter that is too short apart from one that is too long:
- A two-clock module pulse in idle must leave no trace.
- A two-clock stray strand pulse riding on a valid access must not turn it into a fault.
- A three-clock pulse must be taken as a real select.

The fault tests use a double module select, a missing strand and a missing module. They separate the group checks from each other, and they show that a rising strobe cannot force a read after a fault.

// File: rtl/rope_pkg.sv
package rope_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_WAIT_TS = 3'd1,
      ST_READ    = 3'd2,
      ST_CAPT    = 3'd3,
      ST_DRIVE   = 3'd4,
      ST_RELEASE = 3'd5,
      ST_FAULT   = 3'd6
   } resp_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/rope_sel_filter.sv
module rope_sel_filter #(
   parameter int W           = 1,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_PULSE   = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] filt_o
);
   localparam int CW = (MIN_PULSE > 1) ? $clog2(MIN_PULSE + 1) : 1;

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [SYNC_STAGES-1:0] sh_q;
      logic                   s;
      logic                   f_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[SYNC_STAGES-2:0], raw_i[b]};
      end
      assign s = sh_q[SYNC_STAGES-1];

      if (MIN_PULSE <= 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= s;
         end
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               f_q   <= 1'b0;
            end else if (s != f_q) begin
               if (cnt_q == CW'(MIN_PULSE - 1)) begin
                  f_q   <= s;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end else begin
               cnt_q <= '0;
            end
         end
      end

      assign filt_o[b] = f_q;
   end
endmodule

// File: rtl/rope_onehot_enc.sv
module rope_onehot_enc #(
   parameter int N  = 6,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec_i,
   output logic [IW-1:0] idx_o,
   output logic          single_o
);
   localparam int CW = $clog2(N + 1);
   logic [CW-1:0] cnt;

   always_comb begin
      idx_o = '0;
      cnt   = '0;
      for (int i = 0; i < N; i++) begin
         if (vec_i[i]) begin
            idx_o = idx_o | IW'(i);
            cnt   = cnt + CW'(1);
         end
      end
   end

   assign single_o = (cnt == CW'(1));
endmodule

// File: rtl/rope_addr_map.sv
module rope_addr_map #(
   parameter int MOD_IW        = 3,
   parameter int STR_IW        = 4,
   parameter int CORE_W        = 9,
   parameter int WORDS_PER_MOD = 6144,
   parameter int ADDR_W        = 16
) (
   input  logic [MOD_IW-1:0] mod_idx_i,
   input  logic [STR_IW-1:0] str_idx_i,
   input  logic [CORE_W-1:0] core_i,
   output logic [ADDR_W-1:0] addr_o
);
   import rope_pkg::*;
   localparam int MOD_SH = $clog2(WORDS_PER_MOD);

   logic [ADDR_W-1:0] offset;
   assign offset = (ADDR_W'(str_idx_i) << CORE_W) + ADDR_W'(core_i);

   if (is_pow2(WORDS_PER_MOD)) begin : g_shift
      assign addr_o = (ADDR_W'(mod_idx_i) << MOD_SH) | offset;
   end else begin : g_mult
      assign addr_o = ADDR_W'(mod_idx_i) * ADDR_W'(WORDS_PER_MOD) + offset;
   end
endmodule

// File: rtl/rope_resp_fsm.sv
module rope_resp_fsm #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_sel_i,
   input  logic              sel_stable_i,
   input  logic              sel_ok_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ts_i,
   input  logic [DATA_W-1:0] ram_rdata_i,
   input  logic              ram_rpar_i,
   output logic              ram_rd_o,
   output logic [ADDR_W-1:0] ram_addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              par_o,
   output logic              valid_o,
   output logic              err_o
);
   import rope_pkg::*;

   resp_state_e       st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              par_q, valid_q, err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         par_q   <= 1'b0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (any_sel_i && sel_stable_i) begin
                  addr_q <= addr_i;
                  if (sel_ok_i) begin
                     st_q <= ST_WAIT_TS;
                  end else begin
                     st_q  <= ST_FAULT;
                     err_q <= 1'b1;
                  end
               end
            end
            ST_WAIT_TS: if (ts_i) st_q <= ST_READ;
            ST_READ:    st_q <= ST_CAPT;
            ST_CAPT: begin
               data_q  <= ram_rdata_i;
               par_q   <= ram_rpar_i;
               valid_q <= 1'b1;
               st_q    <= ST_DRIVE;
            end
            ST_DRIVE: begin
               if (!ts_i) begin
                  data_q  <= '0;
                  par_q   <= 1'b0;
                  valid_q <= 1'b0;
                  st_q    <= ST_RELEASE;
               end
            end
            ST_RELEASE: if (!any_sel_i) st_q <= ST_IDLE;
            ST_FAULT: begin
               if (!any_sel_i) begin
                  err_q <= 1'b0;
                  st_q  <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ram_rd_o   = (st_q == ST_READ);
   assign ram_addr_o = addr_q;
   assign data_o     = data_q;
   assign par_o      = par_q;
   assign valid_o    = valid_q;
   assign err_o      = err_q;
endmodule

// File: rtl/rope_addr_responder.sv
module rope_addr_responder #(
   parameter int NUM_MODS      = 6,
   parameter int NUM_STRANDS   = 12,
   parameter int CORE_W        = 9,
   parameter int WORDS_PER_MOD = 6144,
   parameter int DATA_W        = 16,
   parameter int SYNC_STAGES   = 2,
   parameter int MIN_PULSE     = 3,
   localparam int ADDR_W       = $clog2(NUM_MODS * WORDS_PER_MOD),
   localparam int MOD_IW       = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1,
   localparam int STR_IW       = (NUM_STRANDS > 1) ? $clog2(NUM_STRANDS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MODS-1:0]    mod_sel_i,
   input  logic [NUM_STRANDS-1:0] strand_sel_i,
   input  logic [CORE_W-1:0]      core_pos_i,
   input  logic                   timing_i,
   output logic                   ram_rd_o,
   output logic [ADDR_W-1:0]      ram_addr_o,
   input  logic [DATA_W-1:0]      ram_rdata_i,
   input  logic                   ram_rpar_i,
   output logic [DATA_W-1:0]      data_o,
   output logic                   par_o,
   output logic                   valid_o,
   output logic                   err_o
);
   localparam int SEL_W = NUM_MODS + NUM_STRANDS + CORE_W;

   initial begin
      if (WORDS_PER_MOD != NUM_STRANDS * (1 << CORE_W))
         $error("module size must equal strands times core positions");
      if (SYNC_STAGES < 2)
         $error("at least two synchroniser stages required");
      if (MIN_PULSE < 1)
         $error("MIN_PULSE must be at least 1");
   end

   logic [NUM_MODS-1:0]    mod_f;
   logic [NUM_STRANDS-1:0] str_f;
   logic [CORE_W-1:0]      core_f;
   logic [0:0]             ts_vec;
   logic                   ts_s;
   logic [SEL_W-1:0]       sel_now, sel_prev_q;
   logic [MOD_IW-1:0]      mod_idx;
   logic [STR_IW-1:0]      str_idx;
   logic                   mod_one, str_one;
   logic [ADDR_W-1:0]      lin_addr;

   rope_sel_filter #(.W(NUM_MODS), .SYNC_STAGES(SYNC_STAGES), .MIN_PULSE(MIN_PULSE))
      u_mod_flt (.clk(clk), .rst_n(rst_n), .raw_i(mod_sel_i), .filt_o(mod_f));
   rope_sel_filter #(.W(NUM_STRANDS), .SYNC_STAGES(SYNC_STAGES), .MIN_PULSE(MIN_PULSE))
      u_str_flt (.clk(clk), .rst_n(rst_n), .raw_i(strand_sel_i), .filt_o(str_f));
   rope_sel_filter #(.W(CORE_W), .SYNC_STAGES(SYNC_STAGES), .MIN_PULSE(MIN_PULSE))
      u_core_flt (.clk(clk), .rst_n(rst_n), .raw_i(core_pos_i), .filt_o(core_f));
   rope_sel_filter #(.W(1), .SYNC_STAGES(SYNC_STAGES), .MIN_PULSE(1))
      u_ts_sync (.clk(clk), .rst_n(rst_n), .raw_i(timing_i), .filt_o(ts_vec));
   assign ts_s = ts_vec[0];

   assign sel_now = {mod_f, str_f, core_f};
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_prev_q <= '0;
      else        sel_prev_q <= sel_now;
   end

   rope_onehot_enc #(.N(NUM_MODS), .IW(MOD_IW))
      u_mod_enc (.vec_i(mod_f), .idx_o(mod_idx), .single_o(mod_one));
   rope_onehot_enc #(.N(NUM_STRANDS), .IW(STR_IW))
      u_str_enc (.vec_i(str_f), .idx_o(str_idx), .single_o(str_one));

   rope_addr_map #(.MOD_IW(MOD_IW), .STR_IW(STR_IW), .CORE_W(CORE_W),
                   .WORDS_PER_MOD(WORDS_PER_MOD), .ADDR_W(ADDR_W))
      u_map (.mod_idx_i(mod_idx), .str_idx_i(str_idx), .core_i(core_f), .addr_o(lin_addr));

   rope_resp_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .any_sel_i(|{mod_f, str_f}),
      .sel_stable_i(sel_now == sel_prev_q),
      .sel_ok_i(mod_one && str_one),
      .addr_i(lin_addr),
      .ts_i(ts_s),
      .ram_rdata_i(ram_rdata_i), .ram_rpar_i(ram_rpar_i),
      .ram_rd_o(ram_rd_o), .ram_addr_o(ram_addr_o),
      .data_o(data_o), .par_o(par_o), .valid_o(valid_o), .err_o(err_o));
endmodule

// File: rtl/rope_addr_responder_chk.sv
module rope_addr_responder_chk #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int TOTAL_WORDS = 36864
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ram_rd_o,
   input logic [ADDR_W-1:0] ram_addr_o,
   input logic [DATA_W-1:0] data_o,
   input logic              par_o,
   input logic              valid_o,
   input logic              err_o,
   input logic              ts_s
);
   p_addr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ram_rd_o |-> (32'(ram_addr_o) < TOTAL_WORDS));

   p_rd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ram_rd_o |=> !ram_rd_o);

   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ram_rd_o |=> $stable(ram_addr_o));

   p_addr_hold_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $stable(ram_addr_o));

   p_rd_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ram_rd_o |-> $past(ts_s));

   p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> (!valid_o || ($stable(data_o) && $stable(par_o))));

   p_clear_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ts_s) |=> !valid_o);

   p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (data_o == '0 && !par_o));

   p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!ram_rd_o && !valid_o));
endmodule

bind rope_addr_responder rope_addr_responder_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOTAL_WORDS(NUM_MODS * WORDS_PER_MOD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ram_rd_o(ram_rd_o), .ram_addr_o(ram_addr_o),
   .data_o(data_o), .par_o(par_o), .valid_o(valid_o), .err_o(err_o), .ts_s(ts_s)
);

// File: tb/rope_addr_responder_tb.sv
module rope_addr_responder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  mod_sel = '0;
   logic [11:0] strand_sel = '0;
   logic [8:0]  core_pos = '0;
   logic        timing = 1'b0;
   logic        ram_rd;
   logic [15:0] ram_addr;
   logic [15:0] ram_rdata = '0;
   logic        ram_rpar = 1'b0;
   logic [15:0] data;
   logic        par, valid, err;

   int n_chk = 0, n_bad = 0, rd_cnt = 0;
   logic [15:0] last_rd_addr = '0;
   bit done = 0;

   always #10 clk = ~clk;

   rope_addr_responder u_dut (
      .clk(clk), .rst_n(rst_n), .mod_sel_i(mod_sel), .strand_sel_i(strand_sel),
      .core_pos_i(core_pos), .timing_i(timing), .ram_rd_o(ram_rd), .ram_addr_o(ram_addr),
      .ram_rdata_i(ram_rdata), .ram_rpar_i(ram_rpar), .data_o(data), .par_o(par),
      .valid_o(valid), .err_o(err));

   function automatic logic [15:0] word_of(input logic [15:0] a);
      return (a * 16'd40503) ^ 16'h5A5A;
   endfunction
   function automatic logic par_of(input logic [15:0] a);
      return (^a) ^ a[3];
   endfunction

   // backing RAM model, one-cycle latency
   always @(posedge clk) begin
      if (ram_rd) begin
         ram_rdata    <= word_of(ram_addr);
         ram_rpar     <= par_of(ram_addr);
         last_rd_addr <= ram_addr;
         rd_cnt       <= rd_cnt + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic release_all();
      mod_sel = '0; strand_sel = '0; core_pos = '0; timing = 1'b0;
      cycles(14);
   endtask

   task automatic wait_valid(output bit seen);
      seen = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (valid) begin seen = 1; break; end
      end
   endtask

   // full good access with checks on address, data, gating and hold
   task automatic do_access(input int m, input int s, input int c,
                            input logic [11:0] stray, input string tag);
      int base;
      bit seen;
      logic [15:0] exp_a;
      exp_a = 16'(m * 6144 + s * 512 + c);
      base = rd_cnt;
      @(negedge clk);
      mod_sel = 6'(1 << m); strand_sel = 12'(1 << s) | stray; core_pos = 9'(c);
      if (stray != 0) begin
         cycles(2);
         strand_sel = 12'(1 << s);
      end
      cycles(12);
      chk({tag, " R4 no read before strobe"}, 32'(rd_cnt - base), 0);
      chk({tag, " R4 no valid before strobe"}, {31'd0, valid}, 0);
      chk({tag, " R8/R7 no fault"}, {31'd0, err}, 0);
      core_pos = ~core_pos;              // R3: late change ignored
      timing = 1'b1;
      wait_valid(seen);
      chk({tag, " R5 valid seen"}, {31'd0, seen}, 1);
      chk({tag, " R1 address"}, {16'd0, last_rd_addr}, {16'd0, exp_a});
      chk({tag, " R2 single read"}, 32'(rd_cnt - base), 1);
      chk({tag, " R5 data"}, {16'd0, data}, {16'd0, word_of(exp_a)});
      chk({tag, " R5 parity"}, {31'd0, par}, {31'd0, par_of(exp_a)});
      cycles(6);
      chk({tag, " R6 valid held"}, {31'd0, valid}, 1);
      chk({tag, " R6 data held"}, {16'd0, data}, {16'd0, word_of(exp_a)});
      chk({tag, " R2 addr held"}, {16'd0, ram_addr}, {16'd0, exp_a});
      timing = 1'b0;
      cycles(8);
      chk({tag, " R6 valid cleared"}, {31'd0, valid}, 0);
      chk({tag, " R6 data cleared"}, {15'd0, data, par}, 0);
      release_all();
   endtask

   task automatic t_reset();
      chk("R6 reset valid", {31'd0, valid}, 0);
      chk("R8 reset err", {31'd0, err}, 0);
      chk("R6 reset data", {15'd0, data, par}, 0);
      chk("R2 reset rd", {31'd0, ram_rd}, 0);
   endtask

   task automatic t_fault(input logic [5:0] m, input logic [11:0] s, input string tag);
      int base;
      base = rd_cnt;
      @(negedge clk);
      mod_sel = m; strand_sel = s; core_pos = 9'd17;
      cycles(12);
      chk({tag, " R8 err raised"}, {31'd0, err}, 1);
      timing = 1'b1;
      cycles(10);
      chk({tag, " R8 no valid"}, {31'd0, valid}, 0);
      chk({tag, " R8 no read"}, 32'(rd_cnt - base), 0);
      timing = 1'b0;
      mod_sel = '0; strand_sel = '0;
      cycles(14);
      chk({tag, " R8 err cleared"}, {31'd0, err}, 0);
   endtask

   task automatic t_idle_glitch();
      int base;
      base = rd_cnt;
      @(negedge clk);
      mod_sel = 6'b000100;
      cycles(2);
      mod_sel = '0;
      cycles(12);
      chk("R7 short pulse no fault", {31'd0, err}, 0);
      timing = 1'b1;
      cycles(10);
      chk("R7 short pulse no read", 32'(rd_cnt - base), 0);
      chk("R7 short pulse no valid", {31'd0, valid}, 0);
      timing = 1'b0;
      cycles(8);
   endtask

   task automatic t_exact_pulse();
      bit seen_err;
      seen_err = 0;
      @(negedge clk);
      mod_sel = 6'b000010;
      cycles(3);
      mod_sel = '0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (err) seen_err = 1;
      end
      chk("R9 exact pulse accepted (module-only fault)", {31'd0, seen_err}, 1);
      cycles(8);
      chk("R9 fault clears after release", {31'd0, err}, 0);
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
      t_reset();
      do_access(0, 0, 0, 12'd0, "corner low");
      do_access(5, 11, 511, 12'd0, "corner high");
      do_access(1, 0, 0, 12'd0, "module step");
      do_access(2, 7, 300, 12'd0, "mid");
      do_access(3, 4, 85, 12'b0100_0000_0000, "stray strand R7");
      t_idle_glitch();
      t_exact_pulse();
      t_fault(6'b001001, 12'b000000000100, "two modules");
      t_fault(6'b010000, 12'b000000000000, "no strand");
      t_fault(6'b000000, 12'b000010000000, "no module");
      t_fault(6'b000001, 12'b000000011000, "two strands");
      do_access(4, 9, 1, 12'd0, "after faults");
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule